// File: doc/BRIEF.md
# Synchronous-Serial Slave Transmitter with Master Watchdog

This block sends a data word over a synchronous serial link in the slave role. An outside master supplies the serial clock. On the first falling edge of a frame, the block captures a word of programmable length, 8 to 32 bits. It then presents that word one bit per rising edge, most significant bit first. The word can be sent as plain binary or as Gray code. An echo option replaces the locally supplied word with the word most recently received by a neighbouring serial receiver channel. This lets one channel relay what another one reads.

After the last bit the block holds the data line low. Once the clock has stayed idle for a monoflop interval, the line returns high. Separately, a watchdog samples frame activity at each tick of the control loop. One status bit reports that no complete word was clocked out during the loop that just ended. A second bit reports that this has happened on two or more consecutive loops. Both the serial clock and the loop tick come from the surrounding system. Line drivers and register access sit outside the block.

Top module: `ssi_slave_tx`

## Requirements
- R1: During and after synchronous reset, `ssi_data` is 1, and `miss_loop` and `miss_multi` are 0.
- R2: While no frame is in progress, `ssi_data` stays 1.
- R3: A falling edge of `ssi_clk` seen while idle starts a frame and captures the word. The effective length L is `cfg_len` clamped to the range 8..32. Each of the next L rising edges drives the next bit onto `ssi_data`, starting at bit L-1 and ending at bit 0.
- R4: With `cfg_gray` = 1, the transmitted value is w XOR (w >> 1). Here w is the selected word masked to its low L bits. With `cfg_gray` = 0, w is sent unchanged.
- R5: With `cfg_echo` = 1, the source word is `echo_word`, and `local_word` has no effect on `ssi_data`. With `cfg_echo` = 0, the source word is `local_word`.
- R6: The falling edge after the L-th rising edge completes the word and drives `ssi_data` to 0. The line stays 0 until `TIMEOUT_CYC` clock cycles pass with no edge on `ssi_clk`, and then returns to 1.
- R7: At each `loop_tick`, `miss_loop` becomes 1 if no word was completed since the previous tick, and 0 otherwise. A word that completes in the same cycle as the tick counts for the loop that is ending.
- R8: At each `loop_tick`, `miss_multi` becomes 1 when the count of consecutive missed loops, including this one, is two or more. The count saturates, and a loop with a completed word clears it.
- R9: `miss_loop` and `miss_multi` change only in the cycle after a `loop_tick`.
- R10: Changes to the source word or to `cfg_len` after a frame has started do not alter the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ssi_clk | input | 1 | Serial clock from the external master (idles high) |
| loop_tick | input | 1 | One-cycle pulse marking the end of a control loop |
| cfg_len | input | CFG_LEN_W | Requested word length in bits |
| cfg_gray | input | 1 | 1 = Gray code, 0 = binary |
| cfg_echo | input | 1 | 1 = transmit the neighbour's received word |
| local_word | input | MAX_BITS | Locally supplied word |
| echo_word | input | MAX_BITS | Word last received by the companion receiver |
| ssi_data | output | 1 | Serial data line (idles high) |
| miss_loop | output | 1 | No complete word during the last loop |
| miss_multi | output | 1 | No complete word for two or more loops |

## Verification
A completed word and a loop tick can fall in the same cycle. The word-completion event and the tick then reach the watchdog together, and the word must be credited to the loop that is closing. The bench provokes this by driving the final falling clock edge, then raising `loop_tick` exactly when the synchronised edge reaches the watchdog, three system cycles later. It judges the outcome by requiring `miss_loop` to be 0 after that tick and 1 after the next, idle tick. This shows that the credit was taken once and then cleared.

// File: rtl/ssi_tx_pkg.sv
package ssi_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_HOLD  = 2'd2
  } tx_state_e;
endpackage

// File: rtl/ssi_sync.sv
// Two-flop synchroniser for the asynchronous serial clock.
module ssi_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ssi_word_prep.sv
// Source select, length clamp, masking, optional Gray code, left alignment.
module ssi_word_prep #(
  parameter int MAX_BITS  = 32,
  parameter int MIN_BITS  = 8,
  parameter int CFG_LEN_W = 6,
  parameter int LEN_W     = $clog2(MAX_BITS + 1)
) (
  input  logic [CFG_LEN_W-1:0] cfg_len,
  input  logic                 cfg_gray,
  input  logic                 cfg_echo,
  input  logic [MAX_BITS-1:0]  local_word,
  input  logic [MAX_BITS-1:0]  echo_word,
  output logic [LEN_W-1:0]     len_eff,
  output logic [MAX_BITS-1:0]  word_left
);
  logic [MAX_BITS-1:0] src, masked, enc;

  always_comb begin
    if (cfg_len < CFG_LEN_W'(MIN_BITS))      len_eff = LEN_W'(MIN_BITS);
    else if (cfg_len > CFG_LEN_W'(MAX_BITS)) len_eff = LEN_W'(MAX_BITS);
    else                                     len_eff = LEN_W'(cfg_len);
  end

  assign src = cfg_echo ? echo_word : local_word;

  for (genvar i = 0; i < MAX_BITS; i++) begin : g_mask
    assign masked[i] = src[i] & (LEN_W'(i) < len_eff);
  end

  assign enc       = cfg_gray ? (masked ^ (masked >> 1)) : masked;
  assign word_left = enc << (LEN_W'(MAX_BITS) - len_eff);
endmodule

// File: rtl/ssi_frame_tx.sv
// Frame engine: capture on first fall, shift on rises, end-of-word low, monoflop.
module ssi_frame_tx
  import ssi_tx_pkg::*;
#(
  parameter int MAX_BITS    = 32,
  parameter int TIMEOUT_CYC = 2000,
  parameter int LEN_W       = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sclk_s,
  input  logic [MAX_BITS-1:0] word_left,
  input  logic [LEN_W-1:0]    len_eff,
  output logic                data_q,
  output logic                frame_done
);
  localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);

  tx_state_e           state;
  logic                sclk_d;
  logic [MAX_BITS-1:0] shreg;
  logic [LEN_W-1:0]    cnt, len_q;
  logic [TMR_W-1:0]    tmr;
  logic                rise, fall;

  assign rise       = sclk_s & ~sclk_d;
  assign fall       = ~sclk_s & sclk_d;
  assign frame_done = (state == ST_SHIFT) && fall && (cnt == len_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      sclk_d <= 1'b1;
      data_q <= 1'b1;
      shreg  <= '0;
      cnt    <= '0;
      len_q  <= '0;
      tmr    <= '0;
    end else begin
      sclk_d <= sclk_s;
      case (state)
        ST_IDLE: begin
          data_q <= 1'b1;
          if (fall) begin
            shreg <= word_left;
            len_q <= len_eff;
            cnt   <= '0;
            tmr   <= '0;
            state <= ST_SHIFT;
          end
        end
        default: begin
          if (state == ST_SHIFT && rise && cnt != len_q) begin
            data_q <= shreg[MAX_BITS-1];
            shreg  <= shreg << 1;
            cnt    <= cnt + 1'b1;
          end
          if (frame_done) begin
            data_q <= 1'b0;
            state  <= ST_HOLD;
          end
          if (rise || fall) tmr <= '0;
          else if (tmr == TMR_W'(TIMEOUT_CYC - 1)) begin
            state  <= ST_IDLE;
            data_q <= 1'b1;
          end else tmr <= tmr + 1'b1;
        end
      endcase
    end
  end

  p_idle_high_r2: assert property (@(posedge clk) disable iff (rst)
    state == ST_IDLE |-> data_q);
  p_hold_low_r6: assert property (@(posedge clk) disable iff (rst)
    state == ST_HOLD |-> !data_q);
  p_done_enters_hold_r6: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> (state == ST_HOLD && !data_q));
endmodule

// File: rtl/ssi_master_watch.sv
// Per-loop master activity monitor with saturating miss counter.
module ssi_master_watch #(
  parameter int MISS_W = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic loop_tick,
  input  logic frame_done,
  output logic miss_loop,
  output logic miss_multi
);
  localparam logic [MISS_W-1:0] MISS_MAX = '1;

  logic              seen;
  logic [MISS_W-1:0] miss_cnt, miss_nxt;
  logic              credited;

  assign credited = seen | frame_done;

  always_comb begin
    if (credited)              miss_nxt = '0;
    else if (miss_cnt != MISS_MAX) miss_nxt = miss_cnt + 1'b1;
    else                       miss_nxt = miss_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen       <= 1'b0;
      miss_cnt   <= '0;
      miss_loop  <= 1'b0;
      miss_multi <= 1'b0;
    end else if (loop_tick) begin
      seen       <= 1'b0;
      miss_cnt   <= miss_nxt;
      miss_loop  <= ~credited;
      miss_multi <= (miss_nxt >= MISS_W'(2));
    end else if (frame_done) begin
      seen <= 1'b1;
    end
  end

  p_multi_implies_loop_r8: assert property (@(posedge clk) disable iff (rst)
    miss_multi |-> miss_loop);
  p_stable_between_ticks_r9: assert property (@(posedge clk) disable iff (rst)
    !loop_tick |=> ($stable(miss_loop) && $stable(miss_multi)));
  p_done_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (loop_tick && frame_done) |=> !miss_loop);
endmodule

// File: rtl/ssi_slave_tx.sv
module ssi_slave_tx #(
  parameter int MAX_BITS    = 32,
  parameter int MIN_BITS    = 8,
  parameter int CFG_LEN_W   = 6,
  parameter int TIMEOUT_CYC = 2000,
  parameter int MISS_W      = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ssi_clk,
  input  logic                 loop_tick,
  input  logic [CFG_LEN_W-1:0] cfg_len,
  input  logic                 cfg_gray,
  input  logic                 cfg_echo,
  input  logic [MAX_BITS-1:0]  local_word,
  input  logic [MAX_BITS-1:0]  echo_word,
  output logic                 ssi_data,
  output logic                 miss_loop,
  output logic                 miss_multi
);
  localparam int LEN_W = $clog2(MAX_BITS + 1);

  logic                sclk_s;
  logic [LEN_W-1:0]    len_eff;
  logic [MAX_BITS-1:0] word_left;
  logic                frame_done;

  ssi_sync #(.STAGES(2), .RST_VAL(1'b1)) i_sync (
    .clk(clk), .rst(rst), .d(ssi_clk), .q(sclk_s));

  ssi_word_prep #(.MAX_BITS(MAX_BITS), .MIN_BITS(MIN_BITS),
                  .CFG_LEN_W(CFG_LEN_W), .LEN_W(LEN_W)) i_prep (
    .cfg_len(cfg_len), .cfg_gray(cfg_gray), .cfg_echo(cfg_echo),
    .local_word(local_word), .echo_word(echo_word),
    .len_eff(len_eff), .word_left(word_left));

  ssi_frame_tx #(.MAX_BITS(MAX_BITS), .TIMEOUT_CYC(TIMEOUT_CYC),
                 .LEN_W(LEN_W)) i_frame (
    .clk(clk), .rst(rst), .sclk_s(sclk_s), .word_left(word_left),
    .len_eff(len_eff), .data_q(ssi_data), .frame_done(frame_done));

  ssi_master_watch #(.MISS_W(MISS_W)) i_watch (
    .clk(clk), .rst(rst), .loop_tick(loop_tick), .frame_done(frame_done),
    .miss_loop(miss_loop), .miss_multi(miss_multi));

  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (ssi_data && !miss_loop && !miss_multi));
endmodule

// File: tb/test_ssi_slave_tx.sv
module test_ssi_slave_tx;
  localparam int TMO = 40;
  localparam int H   = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ssi_clk = 1'b1;
  logic        loop_tick = 1'b0;
  logic [5:0]  cfg_len = 6'd8;
  logic        cfg_gray = 1'b0;
  logic        cfg_echo = 1'b0;
  logic [31:0] local_word = '0;
  logic [31:0] echo_word = '0;
  logic        ssi_data, miss_loop, miss_multi;

  int checks = 0;
  int fails  = 0;
  bit exp_q[$];
  string tag_q[$];
  event sample_ev;

  always #5 clk = ~clk;

  ssi_slave_tx #(.TIMEOUT_CYC(TMO)) i_ssi_slave_tx (
    .clk(clk), .rst(rst), .ssi_clk(ssi_clk), .loop_tick(loop_tick),
    .cfg_len(cfg_len), .cfg_gray(cfg_gray), .cfg_echo(cfg_echo),
    .local_word(local_word), .echo_word(echo_word),
    .ssi_data(ssi_data), .miss_loop(miss_loop), .miss_multi(miss_multi));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops one expected bit per sampling point.
  initial begin
    forever begin
      @(sample_ev);
      if (exp_q.size() == 0) check("R3 unexpected sample", 32'd1, 32'd0);
      else check(tag_q.pop_front(), {31'd0, ssi_data}, {31'd0, exp_q.pop_front()});
    end
  end

  task automatic do_tick();
    @(negedge clk); loop_tick = 1'b1;
    @(negedge clk); loop_tick = 1'b0;
  endtask

  task automatic send_frame(input logic [31:0] loc, input logic [31:0] ech,
                            input int len_cfg, input bit gray, input bit echo,
                            input bit scramble, input bit tick_end, input string tag);
    int L;
    logic [31:0] w;
    L = (len_cfg < 8) ? 8 : ((len_cfg > 32) ? 32 : len_cfg);
    w = echo ? ech : loc;
    if (L < 32) w = w & ((32'd1 << L) - 1);
    if (gray) w = w ^ (w >> 1);
    for (int k = L - 1; k >= 0; k--) begin
      exp_q.push_back(w[k]);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    local_word = loc; echo_word = ech;
    cfg_len = 6'(len_cfg); cfg_gray = gray; cfg_echo = echo;
    wait_n(H);
    check("R2 idle high before frame", {31'd0, ssi_data}, 32'd1);
    ssi_clk = 1'b0;
    if (scramble) begin
      wait_n(4);
      local_word = ~loc; echo_word = ~ech; cfg_len = 6'd8;
      wait_n(H - 4);
    end else wait_n(H);
    for (int k = 0; k < L; k++) begin
      ssi_clk = 1'b1;
      wait_n(H);
      -> sample_ev;
      ssi_clk = 1'b0;
      if (k < L - 1) wait_n(H);
    end
    if (tick_end) begin
      wait_n(2); loop_tick = 1'b1;
      wait_n(1); loop_tick = 1'b0;
      wait_n(H - 3);
    end else wait_n(H);
    check("R6 low after last bit", {31'd0, ssi_data}, 32'd0);
    ssi_clk = 1'b1;
    wait_n(TMO - 4);
    check("R6 low before monoflop expiry", {31'd0, ssi_data}, 32'd0);
    wait_n(12);
    check("R6 high after monoflop expiry", {31'd0, ssi_data}, 32'd1);
    local_word = '0; echo_word = '0;
  endtask

  task automatic finish_run();
    if (exp_q.size() != 0) check("R3 bits left unchecked", exp_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait_n(3);
    check("R1 data during reset", {31'd0, ssi_data}, 32'd1);
    rst = 1'b0;
    wait_n(2);
    check("R1 miss_loop after reset", {31'd0, miss_loop}, 32'd0);
    check("R1 miss_multi after reset", {31'd0, miss_multi}, 32'd0);
    check("R1 data after reset", {31'd0, ssi_data}, 32'd1);

    // Missing master across loops
    do_tick();
    check("R7 first miss", {31'd0, miss_loop}, 32'd1);
    check("R8 single miss not multi", {31'd0, miss_multi}, 32'd0);
    do_tick();
    check("R8 second miss sets multi", {31'd0, miss_multi}, 32'd1);
    do_tick();
    check("R8 saturating multi", {31'd0, miss_multi}, 32'd1);
    check("R7 still missing", {31'd0, miss_loop}, 32'd1);

    // Binary frame, 12 bits
    send_frame(32'hFFFF_FA5C, 32'h0, 12, 1'b0, 1'b0, 1'b0, 1'b0, "R3 binary 12");
    do_tick();
    check("R7 seen clears miss_loop", {31'd0, miss_loop}, 32'd0);
    check("R8 seen clears miss_multi", {31'd0, miss_multi}, 32'd0);

    // Gray and clamp cases
    send_frame(32'hDEAD_BEEF, 32'h0, 32, 1'b1, 1'b0, 1'b0, 1'b0, "R4 gray 32");
    send_frame(32'h0000_01C3, 32'h0, 20, 1'b1, 1'b0, 1'b0, 1'b0, "R4 gray 20");
    send_frame(32'h1234_56B7, 32'h0, 5, 1'b0, 1'b0, 1'b0, 1'b0, "R3 clamp low to 8");
    send_frame(32'h8000_0001, 32'h0, 40, 1'b0, 1'b0, 1'b0, 1'b0, "R3 clamp high to 32");

    // Echo source
    send_frame(32'h0F0F_0F0F, 32'h00AB_CDE5, 24, 1'b0, 1'b1, 1'b0, 1'b0, "R5 echo binary");
    send_frame(32'hFFFF_FFFF, 32'h0000_9C41, 16, 1'b1, 1'b1, 1'b0, 1'b0, "R5 echo gray");

    // Source and length change after frame start
    send_frame(32'h0003_6A59, 32'h0, 18, 1'b0, 1'b0, 1'b1, 1'b0, "R10 mid-frame change");

    do_tick();
    check("R7 frames in loop", {31'd0, miss_loop}, 32'd0);

    // Status holds between ticks
    do_tick();
    check("R7 idle loop", {31'd0, miss_loop}, 32'd1);
    send_frame(32'h0000_00A5, 32'h0, 8, 1'b0, 1'b0, 1'b0, 1'b0, "R3 short frame");
    check("R9 miss_loop held between ticks", {31'd0, miss_loop}, 32'd1);
    check("R9 miss_multi held between ticks", {31'd0, miss_multi}, 32'd0);
    do_tick();
    check("R7 credited at next tick", {31'd0, miss_loop}, 32'd0);

    // Word completion coincident with loop tick
    do_tick();
    check("R7 idle before coincidence", {31'd0, miss_loop}, 32'd1);
    send_frame(32'h0000_3C96, 32'h0, 14, 1'b0, 1'b0, 1'b0, 1'b1, "R7 coincident frame");
    check("R7 coincident completion credited", {31'd0, miss_loop}, 32'd0);
    check("R8 coincident clears multi", {31'd0, miss_multi}, 32'd0);
    do_tick();
    check("R7 credit not carried over", {31'd0, miss_loop}, 32'd1);

    wait_n(4);
    finish_run();
  end
endmodule